// File: doc/BRIEF.md
# I2C Slave Byte Receiver

This block is the receive half of an I2C slave with a 7-bit address. It watches the bus through a two-stage synchronizer and finds START and STOP conditions. It shifts in the address byte and compares it with an address set by the host. After a match, it takes each following byte into a single-byte holding register. On the ninth clock of every byte it either pulls SDA low to acknowledge, or leaves the line released. Every byte accepted from an addressed master raises an interrupt flag.

The host sees three status flags, one data register and one interrupt line. The flags are: buffer full, a sticky overflow, and the direction bit of the last matched address. Reading the data register is signalled by a one-cycle pulse, which empties the buffer. The overflow and interrupt flags clear only on their own pulses. While the buffer is still full, or an earlier overflow has not been cleared, the block refuses to acknowledge. In that state it keeps the old byte and marks an overflow. The system clock must run at least eight times faster than SCL.

Top module: `i2c_rx_slave`

## Requirements
- R1: A falling SDA while SCL is high (START) begins a new address phase from any state. A rising SDA while SCL is high (STOP) ends the transfer and releases SDA. Both are taken from the synchronized lines, so each acts three system clocks after the pin changes.
- R2: The address byte arrives most significant bit first on rising SCL edges. Bits 7..1 are the address and bit 0 is the direction bit, sampled on the eighth rising edge. The address matches when bits 7..1 equal `own_addr`.
- R3: On a matched address byte, `rw_flag` takes bit 0 of that byte (0 means the master writes). If the buffer can accept, `rx_data` takes the whole 8-bit address byte.
- R4: Data bytes are shifted in D7 first. A byte is accepted when `buf_full` and `ovf` are both 0: `rx_data` takes the byte and `buf_full` sets. A one-cycle `rd_buf` pulse clears `buf_full`. After reset, `rx_data`, `buf_full`, `ovf`, `rw_flag` and `irq` are all 0.
- R5: A byte that completes while `buf_full` or `ovf` is 1 sets `ovf`, leaves `rx_data` unchanged and is not acknowledged. `ovf` stays set until a `clr_ovf` pulse, even after the buffer is read.
- R6: `irq` sets on every completed byte of an addressed transfer, the address byte included. It stays set until a `clr_irq` pulse. A byte completing in the same cycle as the pulse wins.
- R7: When the address does not match, no acknowledge is given, `irq` is not set, and `rx_data`, `buf_full` and `ovf` do not change until the next START or STOP.
- R8: `sda_oe` (1 pulls SDA low) is asserted only for an accepted byte. It rises at the SCL fall after the eighth rising edge and drops at the SCL fall after the ninth. At all other times it is 0.
- R9: After a matched address with the direction bit at 1, the address byte is handled as in R3 and acknowledged. The rest of the transfer is then ignored: no data is sampled and no acknowledge is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level (wired bus value) |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain enable) |
| own_addr | input | 7 | Slave address to respond to |
| rd_buf | input | 1 | Host read strobe; empties the buffer |
| clr_irq | input | 1 | Host strobe clearing the interrupt flag |
| clr_ovf | input | 1 | Host strobe clearing the overflow flag |
| rx_data | output | 8 | Last accepted byte |
| buf_full | output | 1 | Buffer holds an unread byte |
| ovf | output | 1 | Sticky overflow flag |
| rw_flag | output | 1 | Direction bit of the last matched address |
| irq | output | 1 | Byte-received interrupt flag |

## Verification
The bench runs a second byte into a full buffer. A design that acknowledged it, or overwrote the held byte, would break R5. It then reads the buffer and sends again without clearing the overflow. A design that dropped the sticky flag together with buffer-full would acknowledge that byte. A foreign address followed by data would, in a faulty design, set the interrupt or load data. A read-direction address and an abandoned partial byte ended by STOP check that the block stops listening and starts cleanly on the next START. Every clock, a behavioural model of the bus timing is compared with the design, so an acknowledge window off by one SCL edge shows up as a mismatch on `sda_oe`.

// File: rtl/i2crx_pkg.sv
package i2crx_pkg;
    parameter int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 2);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_SKIP
    } rx_state_e;

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] sh;
        logic              ackp;
        logic              oe;
        logic              rdmode;
    } fsm_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              full;
        logic              ovf;
        logic              rw;
        logic              irq;
    } host_t;
endpackage

// File: rtl/i2crx_sync.sv
module i2crx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_hi,
    output logic sda_hi,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES:0] scl_d, scl_q, sda_d, sda_q;
    logic scl_c, scl_p, sda_c, sda_p;

    always_comb begin
        scl_d = {scl_q[STAGES-1:0], scl_i};
        sda_d = {sda_q[STAGES-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_c     = scl_q[STAGES-1];
    assign scl_p     = scl_q[STAGES];
    assign sda_c     = sda_q[STAGES-1];
    assign sda_p     = sda_q[STAGES];
    assign scl_hi    = scl_c;
    assign sda_hi    = sda_c;
    assign scl_rise  = scl_c & ~scl_p;
    assign scl_fall  = ~scl_c & scl_p;
    assign start_evt = scl_c & scl_p & sda_p & ~sda_c;
    assign stop_evt  = scl_c & scl_p & ~sda_p & sda_c;
endmodule

// File: rtl/i2crx_fsm.sv
module i2crx_fsm
    import i2crx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_hi,
    input  logic              sda_hi,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              accept,
    output logic              byte_evt,
    output logic              is_addr,
    output logic [BYTE_W-1:0] byte_val,
    output logic              sda_oe
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_WAIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W + 1);

    fsm_t q, n;
    logic [BYTE_W-1:0] nb;

    always_comb begin
        n        = q;
        byte_evt = 1'b0;
        is_addr  = 1'b0;
        nb       = {q.sh, sda_hi};
        byte_val = nb;
        if (stop_evt) begin
            n.st  = ST_IDLE;
            n.oe  = 1'b0;
            n.cnt = '0;
        end else if (start_evt) begin
            n.st     = ST_ADDR;
            n.cnt    = '0;
            n.oe     = 1'b0;
            n.rdmode = 1'b0;
        end else if (q.st == ST_ADDR || q.st == ST_DATA) begin
            if (scl_rise) begin
                if (q.cnt < ACK_WAIT) begin
                    n.sh  = nb[ADDR_W-1:0];
                    n.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST_BIT) begin
                        if (q.st == ST_ADDR && nb[BYTE_W-1:1] != own_addr) begin
                            n.st  = ST_SKIP;
                            n.cnt = '0;
                        end else begin
                            byte_evt = 1'b1;
                            is_addr  = (q.st == ST_ADDR);
                            n.ackp   = accept;
                            if (q.st == ST_ADDR) n.rdmode = nb[0];
                        end
                    end
                end else if (q.cnt == ACK_WAIT) begin
                    n.cnt = ACK_SLOT;
                end
            end else if (scl_fall) begin
                if (q.cnt == ACK_WAIT) begin
                    n.oe = q.ackp;
                end else if (q.cnt == ACK_SLOT) begin
                    n.oe  = 1'b0;
                    n.cnt = '0;
                    n.st  = q.rdmode ? ST_SKIP : ST_DATA;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, cnt: '0, sh: '0, ackp: 1'b0, oe: 1'b0, rdmode: 1'b0};
        else        q <= n;
    end

    assign sda_oe = q.oe;

    // R8: the pull-down only ever starts while SCL is low
    assert_oe_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> !scl_hi);
    // R7: a skipped transfer never drives the line
    assert_skip_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SKIP) |-> !q.oe);
    // R1: a STOP leaves SDA released on the next cycle
    assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);
endmodule

// File: rtl/i2crx_regs.sv
module i2crx_regs
    import i2crx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_evt,
    input  logic              is_addr,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              rd_buf,
    input  logic              clr_irq,
    input  logic              clr_ovf,
    output logic              accept,
    output logic [BYTE_W-1:0] rx_data,
    output logic              buf_full,
    output logic              ovf,
    output logic              rw_flag,
    output logic              irq
);
    host_t q, n;

    always_comb begin
        n      = q;
        accept = !q.full && !q.ovf;
        if (rd_buf)  n.full = 1'b0;
        if (clr_ovf) n.ovf  = 1'b0;
        if (clr_irq) n.irq  = 1'b0;
        if (byte_evt) begin
            n.irq = 1'b1;
            if (is_addr) n.rw = byte_val[0];
            if (accept) begin
                n.data = byte_val;
                n.full = 1'b1;
            end else begin
                n.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign rx_data  = q.data;
    assign buf_full = q.full;
    assign ovf      = q.ovf;
    assign rw_flag  = q.rw;
    assign irq      = q.irq;

    // R5: overflow is sticky until its own clear strobe
    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.ovf) |-> $past(clr_ovf));
    // R5: held byte is never replaced while the buffer was full or overflowed
    assert_no_overwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.data) |-> $past(accept));
    // R4: buffer-full drops only on a host read
    assert_full_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.full) |-> $past(rd_buf));
    // R6: interrupt drops only on a host clear
    assert_irq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.irq) |-> $past(clr_irq));
endmodule

// File: rtl/i2c_rx_slave.sv
module i2c_rx_slave
    import i2crx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              rd_buf,
    input  logic              clr_irq,
    input  logic              clr_ovf,
    output logic [BYTE_W-1:0] rx_data,
    output logic              buf_full,
    output logic              ovf,
    output logic              rw_flag,
    output logic              irq
);
    logic scl_hi, sda_hi, scl_rise, scl_fall, start_evt, stop_evt;
    logic accept, byte_evt, is_addr;
    logic [BYTE_W-1:0] byte_val;

    i2crx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_hi(scl_hi), .sda_hi(sda_hi), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    i2crx_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_hi(scl_hi), .sda_hi(sda_hi),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt),
        .stop_evt(stop_evt), .own_addr(own_addr), .accept(accept),
        .byte_evt(byte_evt), .is_addr(is_addr), .byte_val(byte_val), .sda_oe(sda_oe)
    );

    i2crx_regs u_regs (
        .clk(clk), .rst_n(rst_n), .byte_evt(byte_evt), .is_addr(is_addr),
        .byte_val(byte_val), .rd_buf(rd_buf), .clr_irq(clr_irq), .clr_ovf(clr_ovf),
        .accept(accept), .rx_data(rx_data), .buf_full(buf_full), .ovf(ovf),
        .rw_flag(rw_flag), .irq(irq)
    );
endmodule

// File: tb/tb_i2c_rx_slave.sv
`timescale 1ns/1ps
module tb_i2c_rx_slave;
    localparam logic [6:0] OWN = 7'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic rd_buf = 1'b0, clr_irq = 1'b0, clr_ovf = 1'b0;
    logic sda_oe, buf_full, ovf, rw_flag, irq;
    logic [7:0] rx_data;
    logic scl_i, sda_i;
    int n_cmp = 0, n_bad = 0;
    bit running = 1'b0, done = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_i = scl_m;
    assign sda_i = sda_m & ~sda_oe;

    i2c_rx_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
        .own_addr(OWN), .rd_buf(rd_buf), .clr_irq(clr_irq), .clr_ovf(clr_ovf),
        .rx_data(rx_data), .buf_full(buf_full), .ovf(ovf), .rw_flag(rw_flag), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic hs[$], hd[$];
    int mph, mcnt, mshift, mack, moe, mrd, mval;
    int e_data, e_full, e_ovf, e_rw, e_irq;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs = '{1'b1, 1'b1, 1'b1, 1'b1};
            hd = '{1'b1, 1'b1, 1'b1, 1'b1};
            mph = 0; mcnt = 0; mshift = 0; mack = 0; moe = 0; mrd = 0; mval = 0;
            e_data = 0; e_full = 0; e_ovf = 0; e_rw = 0; e_irq = 0;
        end else begin
            int ofull, oovf, evt, evaddr;
            logic cs, ps, cd, pd;
            hs.push_front(scl_i);
            hd.push_front(sda_i);
            void'(hs.pop_back());
            void'(hd.pop_back());
            cs = hs[2]; ps = hs[3]; cd = hd[2]; pd = hd[3];
            ofull = e_full; oovf = e_ovf; evt = 0; evaddr = 0;
            if (ps && cs && !pd && cd) begin
                mph = 0; moe = 0; mcnt = 0;
            end else if (ps && cs && pd && !cd) begin
                mph = 1; mcnt = 0; moe = 0; mrd = 0;
            end else if (mph == 1 || mph == 2) begin
                if (!ps && cs) begin
                    if (mcnt < 8) begin
                        mshift = ((mshift << 1) | int'(cd)) & 255;
                        mcnt++;
                        if (mcnt == 8) begin
                            if (mph == 1 && (mshift >> 1) != int'(OWN)) begin
                                mph = 3; mcnt = 0;
                            end else begin
                                evt = 1; evaddr = (mph == 1); mval = mshift;
                                mack = (ofull == 0 && oovf == 0);
                                if (mph == 1) mrd = mshift & 1;
                            end
                        end
                    end else if (mcnt == 8) mcnt = 9;
                end else if (ps && !cs) begin
                    if (mcnt == 8) moe = mack;
                    else if (mcnt == 9) begin
                        moe = 0; mcnt = 0; mph = (mrd != 0) ? 3 : 2;
                    end
                end
            end
            if (rd_buf)  e_full = 0;
            if (clr_ovf) e_ovf = 0;
            if (clr_irq) e_irq = 0;
            if (evt != 0) begin
                e_irq = 1;
                if (evaddr != 0) e_rw = mval & 1;
                if (ofull == 0 && oovf == 0) begin
                    e_data = mval; e_full = 1;
                end else e_ovf = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && running) begin
            chk("R8 sda_oe", int'(sda_oe), moe);
            chk("R3 rx_data", int'(rx_data), e_data);
            chk("R4 buf_full", int'(buf_full), e_full);
            chk("R5 ovf", int'(ovf), e_ovf);
            chk("R6 irq", int'(irq), e_irq);
            chk("R3 rw_flag", int'(rw_flag), e_rw);
        end
    end

    // ---------------- bus and host tasks ----------------
    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_n(5);
        scl_m = 1'b1; wait_n(10);
        sda_m = 1'b0; wait_n(10);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wait_n(5); sda_m = 1'b0; wait_n(5);
        scl_m = 1'b1; wait_n(10);
        sda_m = 1'b1; wait_n(20);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            wait_n(5); sda_m = b[i]; wait_n(5);
            scl_m = 1'b1; wait_n(10);
            scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output int ack);
        send_bits(b, 8);
        wait_n(5); sda_m = 1'b1; wait_n(5);
        scl_m = 1'b1; wait_n(5);
        ack = (sda_i == 1'b0) ? 1 : 0;
        wait_n(5);
        scl_m = 1'b0;
    endtask

    task automatic host_pulse(input int which);
        @(negedge clk);
        case (which)
            0: rd_buf = 1'b1;
            1: clr_irq = 1'b1;
            default: clr_ovf = 1'b1;
        endcase
        @(negedge clk);
        rd_buf = 1'b0; clr_irq = 1'b0; clr_ovf = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int a;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);
        // R4: reset values
        chk("R4 reset rx_data", int'(rx_data), 0);
        chk("R4 reset flags", int'({buf_full, ovf, rw_flag, irq, sda_oe}), 0);
        running = 1'b1;
        wait_n(10);

        // R2 R3: write address accepted
        bus_start();
        send_byte({OWN, 1'b0}, a);
        chk("R2 address ack", a, 1);
        chk("R3 address byte loaded", int'(rx_data), 8'hB4);
        chk("R3 rw_flag write", int'(rw_flag), 0);
        chk("R6 irq on address", int'(irq), 1);
        host_pulse(0); host_pulse(1);
        chk("R4 read empties buffer", int'(buf_full), 0);
        chk("R6 irq cleared", int'(irq), 0);
        // R4 data byte
        send_byte(8'h3C, a);
        chk("R4 data ack", a, 1);
        chk("R4 data loaded", int'(rx_data), 8'h3C);
        // R5 overflow: buffer still full
        send_byte(8'hC3, a);
        chk("R5 no ack when full", a, 0);
        chk("R5 ovf set", int'(ovf), 1);
        chk("R5 data kept", int'(rx_data), 8'h3C);
        host_pulse(0);
        send_byte(8'h11, a);
        chk("R5 sticky ovf blocks ack", a, 0);
        chk("R5 data kept after read", int'(rx_data), 8'h3C);
        chk("R5 buffer stays empty", int'(buf_full), 0);
        host_pulse(2);
        chk("R5 ovf cleared by host", int'(ovf), 0);
        send_byte(8'h22, a);
        chk("R4 ack after clear", a, 1);
        chk("R4 new data", int'(rx_data), 8'h22);
        bus_stop();
        chk("R6 irq held until cleared", int'(irq), 1);
        chk("R8 released after stop", int'(sda_oe), 0);
        host_pulse(0); host_pulse(1);

        // R7: foreign address
        bus_start();
        send_byte(8'h5C, a);
        chk("R7 no ack foreign", a, 0);
        send_byte(8'hFF, a);
        chk("R7 data ignored ack", a, 0);
        chk("R7 no irq", int'(irq), 0);
        chk("R7 buffer untouched", int'({buf_full, ovf}), 0);
        chk("R7 data untouched", int'(rx_data), 8'h22);
        bus_stop();

        // R9: read direction
        bus_start();
        send_byte({OWN, 1'b1}, a);
        chk("R9 read address ack", a, 1);
        chk("R9 rw_flag read", int'(rw_flag), 1);
        chk("R9 address byte loaded", int'(rx_data), 8'hB5);
        host_pulse(0); host_pulse(1);
        send_byte(8'h00, a);
        chk("R9 rest ignored ack", a, 0);
        chk("R9 rest ignored flags", int'({buf_full, ovf, irq}), 0);
        bus_stop();

        // R1: STOP in the middle of a byte, then a fresh START
        bus_start();
        send_bits(8'hB4, 3);
        bus_stop();
        chk("R1 aborted byte no irq", int'(irq), 0);
        bus_start();
        send_byte({OWN, 1'b0}, a);
        chk("R1 restart ack", a, 1);
        chk("R1 restart loaded", int'(rx_data), 8'hB4);
        // R1: repeated START mid-transfer restarts address phase
        host_pulse(0);
        send_bits(8'hAA, 2);
        bus_start();
        send_byte({OWN, 1'b0}, a);
        chk("R1 repeated start ack", a, 1);
        bus_stop();

        running = 1'b0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule